// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Tracker

This block watches the command bus of a registered DDR SDRAM module. On every rising clock it decodes chip select, the three strobes (row, column, write), the bank select and the address. For each of the four internal banks it keeps a state (idle, open, or closing under auto-precharge), the row last opened and a set of timers. The timers count the cycles since the last activate, the last read, the last write and the last precharge.

Every decoded command gets a verdict one cycle later. The verdict says whether the command was legal in the current bank state and whether it met the minimum timing. When it did not, the verdict gives a violation code. A rejected command leaves every bank exactly as it was. All nanosecond limits are turned into whole cycles by rounding up against a clock-period parameter.

A separate per-bank flag rises when a bank has stayed open longer than the maximum activate-to-precharge time. Data strobes, the data path, electrical timing and refresh scheduling are outside this block.

Top module: `ddr_bank_guard`

## Requirements
- R1: Strobe encodings {ras_n,cas_n,we_n} are: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. A command sampled at clock edge N is reported after edge N: res_valid high, res_ok set, and res_code 0 when legal. A no-op gives res_valid low. After reset all banks are idle, all rows are 0 and no result is valid.
- R2: While cs_n is high, nothing is decoded. No result appears and no bank changes state. Timers and pending auto-precharges keep running.
- R3: An activate to an idle bank that meets timing opens it and stores addr as its row. An activate to an open or closing bank gives code 1 (state).
- R4: A read or write to a bank that is not open gives code 1. One issued fewer than ceil(tRCD/tCK) edges after that bank's activate gives code 2.
- R5: An activate to an idle bank is checked in this order. Fewer than ceil(tRP/tCK) edges since the bank's precharge gives code 3. Fewer than ceil(tRC/tCK) edges since its previous activate gives code 4. Fewer than ceil(tRRD/tCK) edges since any accepted activate gives code 5.
- R6: A precharge with addr[10] low closes only bank ba. On an idle bank it is a legal no-op. On a closing bank it gives code 1. On an open bank it gives code 6 below ceil(tRAS_min/tCK) edges since the activate. It gives code 7 when a write is fewer than WRITE_LAT+BURST_LEN/2+ceil(tWR/tCK) edges back, or a read is fewer than BURST_LEN/2 edges back.
- R7: A precharge with addr[10] high applies to all banks whatever ba holds. If any bank objects, the code of the lowest-numbered objecting bank is reported and no bank closes.
- R8: A legal read or write with addr[10] high puts the bank into the closing state. The bank is idle for commands issued D edges later, with D = BURST_LEN/2+ceil(tRP/tCK) for a read and D = WRITE_LAT+BURST_LEN/2+ceil(tWR/tCK)+ceil(tRP/tCK) for a write. Any command aimed at a closing bank gives code 1.
- R9: A rejected command changes no bank state, row or timer.
- R10: ras_overdue[b] is high while bank b is open and more than ceil(tRAS_max/tCK) edges have passed since its activate. A precharge at that point is still legal.
- R11: Refresh and mode set give code 1 if any bank is not idle. They give code 3 if any bank was precharged fewer than ceil(tRP/tCK) edges back. The lowest-numbered objecting bank decides. Burst stop is always legal.
- R12: Every limit in cycles is ceil(limit_ps / TCK_PS), so a command exactly at the limit is legal and one edge earlier is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select |
| addr | input | ROW_W | Row / column address; bit 10 selects auto-precharge or all banks |
| res_valid | output | 1 | A command was decoded at the previous edge |
| res_ok | output | 1 | That command was legal and on time |
| res_code | output | 3 | Violation code (0 none, 1 state, 2 tRCD, 3 tRP, 4 tRC, 5 tRRD, 6 tRAS, 7 recovery) |
| bank_open | output | NB | Bank is open |
| bank_ap | output | NB | Bank is closing under auto-precharge |
| ras_overdue | output | NB | Bank open past the maximum activate-to-precharge time |
| bank_row | output | NB*ROW_W | Row last opened in each bank, bank b at bits b*ROW_W and up |

## Verification
Directed sequences place each command one edge short of its limit and then exactly at it. This separates the tRCD, tRP, tRC and tRRD checks and their priority. The bench sets tRC longer than tRAS plus tRP so the tRC check can fire on its own. Precharge-all is tried both with one bank that objects and with none, which shows whether a rejected command still closes banks. Read and write auto-precharge are probed at each edge of the closing window. A long constrained-random stream of mixed commands, deselects and banks then compares every output on every clock against a behavioural model.

// File: rtl/bkg_pkg.sv
package bkg_pkg;

   typedef enum logic [2:0] {
      C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
   } cmd_e;

   typedef enum logic [2:0] {
      E_NONE  = 3'd0,
      E_STATE = 3'd1,
      E_RCD   = 3'd2,
      E_RP    = 3'd3,
      E_RC    = 3'd4,
      E_RRD   = 3'd5,
      E_RAS   = 3'd6,
      E_RECOV = 3'd7
   } err_e;

   typedef enum logic [1:0] {
      B_IDLE, B_OPEN, B_CLOSING
   } bst_e;

   function automatic int unsigned ps2cyc(input int unsigned ps, input int unsigned tck);
      return (ps + tck - 1) / tck;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bkg_decode.sv
module bkg_decode
   import bkg_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      cmd = C_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            3'b000:  cmd = C_MRS;
            3'b110:  cmd = C_BST;
            default: cmd = C_NOP;
         endcase
      end
   end

endmodule

// File: rtl/bkg_bank.sv
module bkg_bank
   import bkg_pkg::*;
#(
   parameter int unsigned CW        = 8,
   parameter int unsigned APW       = 4,
   parameter int unsigned ROW_W     = 13,
   parameter int unsigned SATV      = 200,
   parameter int unsigned K_RCD     = 3,
   parameter int unsigned K_RP      = 3,
   parameter int unsigned K_RC      = 9,
   parameter int unsigned K_RASMIN  = 6,
   parameter int unsigned K_RASMAX  = 100,
   parameter int unsigned K_RD2PRE  = 2,
   parameter int unsigned K_WR2PRE  = 5,
   parameter int unsigned K_RDAP    = 5,
   parameter int unsigned K_WRAP    = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_e             cmd_i,
   input  logic             hit_i,
   input  logic             ap_i,
   input  logic             rrd_short_i,
   input  logic             accept_i,
   input  logic [ROW_W-1:0] row_i,
   output err_e             code_o,
   output logic             open_o,
   output logic             closing_o,
   output logic             overdue_o,
   output logic [ROW_W-1:0] row_o
);

   localparam logic [CW-1:0]  SAT      = CW'(SATV);
   localparam logic [CW-1:0]  L_RCD    = CW'(K_RCD);
   localparam logic [CW-1:0]  L_RP     = CW'(K_RP);
   localparam logic [CW-1:0]  L_RC     = CW'(K_RC);
   localparam logic [CW-1:0]  L_RASMIN = CW'(K_RASMIN);
   localparam logic [CW-1:0]  L_RASMAX = CW'(K_RASMAX);
   localparam logic [CW-1:0]  L_RD2PRE = CW'(K_RD2PRE);
   localparam logic [CW-1:0]  L_WR2PRE = CW'(K_WR2PRE);
   localparam logic [APW-1:0] L_RDAP   = APW'(K_RDAP - 1);
   localparam logic [APW-1:0] L_WRAP   = APW'(K_WRAP - 1);
   localparam logic [CW-1:0]  ONE      = CW'(1);

   bst_e           st;
   logic [CW-1:0]  s_act, s_pre, s_rd, s_wr;
   logic [APW-1:0] ap_cnt;
   logic [ROW_W-1:0] row_q;

   function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
      return (v >= SAT) ? SAT : v + ONE;
   endfunction

   // verdict for the command on the bus, as seen by this bank
   always_comb begin
      code_o = E_NONE;
      unique case (cmd_i)
         C_ACT: if (hit_i) begin
            if (st != B_IDLE)        code_o = E_STATE;
            else if (s_pre < L_RP)   code_o = E_RP;
            else if (s_act < L_RC)   code_o = E_RC;
            else if (rrd_short_i)    code_o = E_RRD;
         end
         C_RD, C_WR: if (hit_i) begin
            if (st != B_OPEN)        code_o = E_STATE;
            else if (s_act < L_RCD)  code_o = E_RCD;
         end
         C_PRE: if (hit_i) begin
            if (st == B_CLOSING)     code_o = E_STATE;
            else if (st == B_OPEN) begin
               if (s_act < L_RASMIN) code_o = E_RAS;
               else if ((s_wr < L_WR2PRE) || (s_rd < L_RD2PRE))
                                     code_o = E_RECOV;
            end
         end
         C_REF, C_MRS: begin
            if (st != B_IDLE)        code_o = E_STATE;
            else if (s_pre < L_RP)   code_o = E_RP;
         end
         default: code_o = E_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= B_IDLE;
         s_act  <= SAT;
         s_pre  <= SAT;
         s_rd   <= SAT;
         s_wr   <= SAT;
         ap_cnt <= '0;
         row_q  <= '0;
      end else begin
         s_act <= bump(s_act);
         s_pre <= bump(s_pre);
         s_rd  <= bump(s_rd);
         s_wr  <= bump(s_wr);
         if (st == B_CLOSING) begin
            if (ap_cnt == APW'(1)) begin
               st    <= B_IDLE;
               s_pre <= SAT;
            end else begin
               ap_cnt <= ap_cnt - APW'(1);
            end
         end
         if (accept_i && hit_i) begin
            unique case (cmd_i)
               C_ACT: begin
                  st    <= B_OPEN;
                  row_q <= row_i;
                  s_act <= ONE;
               end
               C_RD: begin
                  s_rd <= ONE;
                  if (ap_i) begin
                     st     <= B_CLOSING;
                     ap_cnt <= L_RDAP;
                  end
               end
               C_WR: begin
                  s_wr <= ONE;
                  if (ap_i) begin
                     st     <= B_CLOSING;
                     ap_cnt <= L_WRAP;
                  end
               end
               C_PRE: if (st == B_OPEN) begin
                  st    <= B_IDLE;
                  s_pre <= ONE;
               end
               default: ;
            endcase
         end
      end
   end

   assign open_o    = (st == B_OPEN);
   assign closing_o = (st == B_CLOSING);
   assign overdue_o = (st == B_OPEN) && (s_act > L_RASMAX);
   assign row_o     = row_q;

   p_act_hits_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && hit_i && cmd_i == C_ACT) |-> (st == B_IDLE));

   p_reject_holds_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept_i && st == B_OPEN) |=> (st == B_OPEN));

   p_ap_from_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(closing_o) |-> $past(open_o));

   p_fresh_act_not_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && hit_i && cmd_i == C_ACT) |=> !overdue_o);

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
   import bkg_pkg::*;
#(
   parameter int unsigned BA_W        = 2,
   parameter int unsigned ROW_W       = 13,
   parameter int unsigned TCK_PS      = 7500,
   parameter int unsigned TRCD_PS     = 20000,
   parameter int unsigned TRP_PS      = 20000,
   parameter int unsigned TRAS_MIN_PS = 45000,
   parameter int unsigned TRAS_MAX_PS = 120000000,
   parameter int unsigned TRC_PS      = 65000,
   parameter int unsigned TRRD_PS     = 15000,
   parameter int unsigned TWR_PS      = 15000,
   parameter int unsigned BURST_LEN   = 4,
   parameter int unsigned WRITE_LAT   = 1,
   localparam int unsigned NB         = 1 << BA_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic [BA_W-1:0]     ba,
   input  logic [ROW_W-1:0]    addr,
   output logic                res_valid,
   output logic                res_ok,
   output logic [2:0]          res_code,
   output logic [NB-1:0]       bank_open,
   output logic [NB-1:0]       bank_ap,
   output logic [NB-1:0]       ras_overdue,
   output logic [NB*ROW_W-1:0] bank_row
);

   localparam int unsigned AP_BIT   = 10;
   localparam int unsigned K_RCD    = ps2cyc(TRCD_PS, TCK_PS);
   localparam int unsigned K_RP     = ps2cyc(TRP_PS, TCK_PS);
   localparam int unsigned K_RASMIN = ps2cyc(TRAS_MIN_PS, TCK_PS);
   localparam int unsigned K_RASMAX = ps2cyc(TRAS_MAX_PS, TCK_PS);
   localparam int unsigned K_RC     = ps2cyc(TRC_PS, TCK_PS);
   localparam int unsigned K_RRD    = ps2cyc(TRRD_PS, TCK_PS);
   localparam int unsigned K_WR     = ps2cyc(TWR_PS, TCK_PS);
   localparam int unsigned BEATS    = BURST_LEN / 2;
   localparam int unsigned K_RD2PRE = BEATS;
   localparam int unsigned K_WR2PRE = WRITE_LAT + BEATS + K_WR;
   localparam int unsigned K_RDAP   = BEATS + K_RP;
   localparam int unsigned K_WRAP   = K_WR2PRE + K_RP;
   localparam int unsigned SATV     = umax(umax(umax(K_RASMAX + 1, K_RC), umax(K_WR2PRE, K_RP)),
                                           umax(K_RCD, K_RASMIN));
   localparam int unsigned CW       = $clog2(SATV + 1);
   localparam int unsigned APW      = $clog2(K_WRAP + 1);

   // elaboration-time parameter checks
   if (TCK_PS == 0) begin : g_bad_tck
      $error("TCK_PS must be non-zero");
   end
   if (ROW_W <= AP_BIT) begin : g_bad_row
      $error("ROW_W must cover the auto-precharge address bit");
   end
   if (!(BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
      $error("BURST_LEN must be 2, 4 or 8");
   end

   cmd_e          cmd;
   logic          a10;
   logic          accept;
   logic          rrd_short;
   err_e          verdict;
   err_e          bcode [NB];
   logic [NB-1:0] hit;

   bkg_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign a10 = addr[AP_BIT];

   // bank-to-bank activate spacing: a counter only when the limit exceeds one cycle
   if (K_RRD <= 1) begin : g_rrd_none
      assign rrd_short = 1'b0;
   end else begin : g_rrd_cnt
      localparam int unsigned RW = $clog2(K_RRD + 1);
      localparam logic [RW-1:0] L_RRD = RW'(K_RRD);
      logic [RW-1:0] s_any;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        s_any <= L_RRD;
         else if (accept && cmd == C_ACT)   s_any <= RW'(1);
         else if (s_any < L_RRD)            s_any <= s_any + RW'(1);
      end
      assign rrd_short = (s_any < L_RRD);
   end

   for (genvar g = 0; g < NB; g++) begin : g_bank
      assign hit[g] = (ba == BA_W'(g)) || (cmd == C_PRE && a10);
      bkg_bank #(
         .CW(CW), .APW(APW), .ROW_W(ROW_W), .SATV(SATV),
         .K_RCD(K_RCD), .K_RP(K_RP), .K_RC(K_RC),
         .K_RASMIN(K_RASMIN), .K_RASMAX(K_RASMAX),
         .K_RD2PRE(K_RD2PRE), .K_WR2PRE(K_WR2PRE),
         .K_RDAP(K_RDAP), .K_WRAP(K_WRAP)
      ) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .cmd_i       (cmd),
         .hit_i       (hit[g]),
         .ap_i        (a10),
         .rrd_short_i (rrd_short),
         .accept_i    (accept),
         .row_i       (addr),
         .code_o      (bcode[g]),
         .open_o      (bank_open[g]),
         .closing_o   (bank_ap[g]),
         .overdue_o   (ras_overdue[g]),
         .row_o       (bank_row[g*ROW_W +: ROW_W])
      );
   end

   // lowest-numbered objecting bank wins
   always_comb begin
      verdict = E_NONE;
      for (int i = NB - 1; i >= 0; i--) begin
         if (bcode[i] != E_NONE) verdict = bcode[i];
      end
   end

   assign accept = (cmd != C_NOP) && (verdict == E_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_ok    <= 1'b0;
         res_code  <= 3'd0;
      end else begin
         res_valid <= (cmd != C_NOP);
         res_ok    <= accept;
         res_code  <= verdict;
      end
   end

   p_result_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_NOP) |=> res_valid);

   p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !res_valid);

   p_pre_all_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd == C_PRE && a10) |=> (bank_open == '0 && bank_ap == '0));

endmodule

// File: tb/ddr_bank_guard_tb_top.sv
`timescale 1ns/1ps
module ddr_bank_guard_tb_top;

   localparam int TCK = 5000;
   function automatic int cdiv(input int ps);
      return (ps + TCK - 1) / TCK;
   endfunction
   localparam int RCD     = cdiv(20000);
   localparam int RP      = cdiv(20000);
   localparam int RAS_MIN = cdiv(45000);
   localparam int RAS_MAX = cdiv(100000);
   localparam int RC      = cdiv(75000);
   localparam int RRD     = cdiv(15000);
   localparam int WRC     = cdiv(15000);
   localparam int BEATS   = 2;
   localparam int WR2PRE  = 1 + BEATS + WRC;
   localparam int RD2PRE  = BEATS;
   localparam int RDAP    = BEATS + RP;
   localparam int WRAP    = WR2PRE + RP;
   localparam int FAR     = -100000;

   logic clk = 1'b0;
   logic rst_n;
   logic cs_n, ras_n, cas_n, we_n;
   logic [1:0]  ba;
   logic [12:0] addr;
   logic        res_valid, res_ok;
   logic [2:0]  res_code;
   logic [3:0]  bank_open, bank_ap, ras_overdue;
   logic [51:0] bank_row;

   always #2.5 clk = ~clk;

   ddr_bank_guard #(.TCK_PS(5000), .TRAS_MAX_PS(100000), .TRC_PS(75000)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .res_valid(res_valid), .res_ok(res_ok), .res_code(res_code),
      .bank_open(bank_open), .bank_ap(bank_ap), .ras_overdue(ras_overdue), .bank_row(bank_row)
   );

   // behavioural reference: 0 idle, 1 open, 2 closing
   int st[4], t_act[4], t_pre[4], t_rd[4], t_wr[4], ap_end[4], rowm[4];
   int t_any, now;
   int e_valid, e_ok, e_code;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   string req = "R1";

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         st[i] = 0; t_act[i] = FAR; t_pre[i] = FAR; t_rd[i] = FAR; t_wr[i] = FAR;
         ap_end[i] = 0; rowm[i] = 0;
      end
      t_any = FAR; now = 0; e_valid = 0; e_ok = 0; e_code = 0;
   endtask

   // kinds: 0 nop 1 act 2 rd 3 wr 4 pre 5 ref 6 mrs 7 bst
   task automatic model_step(input int c_s, input int r, input int ca, input int w,
                             input int b, input int a);
      int k, code, ap, lo, hi, ci;
      k = 0;
      if (c_s == 0) begin
         case ({r[0], ca[0], w[0]})
            3'b011: k = 1; 3'b101: k = 2; 3'b100: k = 3; 3'b010: k = 4;
            3'b001: k = 5; 3'b000: k = 6; 3'b110: k = 7; default: k = 0;
         endcase
      end
      ap = (a >> 10) & 1;
      code = 0;
      if (k == 1) begin
         if (st[b] != 0) code = 1;
         else if (now - t_pre[b] < RP) code = 3;
         else if (now - t_act[b] < RC) code = 4;
         else if (now - t_any < RRD) code = 5;
      end else if (k == 2 || k == 3) begin
         if (st[b] != 1) code = 1;
         else if (now - t_act[b] < RCD) code = 2;
      end else if (k == 4 || k == 5 || k == 6) begin
         lo = (k == 4 && ap == 0) ? b : 0;
         hi = (k == 4 && ap == 0) ? b : 3;
         for (int i = hi; i >= lo; i--) begin
            ci = 0;
            if (k == 4) begin
               if (st[i] == 2) ci = 1;
               else if (st[i] == 1) begin
                  if (now - t_act[i] < RAS_MIN) ci = 6;
                  else if (now - t_wr[i] < WR2PRE || now - t_rd[i] < RD2PRE) ci = 7;
               end
            end else begin
               if (st[i] != 0) ci = 1;
               else if (now - t_pre[i] < RP) ci = 3;
            end
            if (ci != 0) code = ci;
         end
      end
      e_valid = (k != 0);
      e_code  = code;
      e_ok    = (k != 0) && (code == 0);
      if (e_ok) begin
         case (k)
            1: begin st[b] = 1; t_act[b] = now; t_any = now; rowm[b] = a; end
            2: begin t_rd[b] = now; if (ap) begin st[b] = 2; ap_end[b] = now + RDAP; end end
            3: begin t_wr[b] = now; if (ap) begin st[b] = 2; ap_end[b] = now + WRAP; end end
            4: for (int i = 0; i < 4; i++)
                  if ((ap || i == b) && st[i] == 1) begin st[i] = 0; t_pre[i] = now; end
            default: ;
         endcase
      end
      now++;
      for (int i = 0; i < 4; i++)
         if (st[i] == 2 && now >= ap_end[i]) begin st[i] = 0; t_pre[i] = FAR; end
   endtask

   task automatic check(input string nm, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, nm, got, exp);
      end
   endtask

   task automatic compare_all();
      check("res_valid", int'(res_valid), e_valid);
      check("res_ok", int'(res_ok), e_ok);
      check("res_code", int'(res_code), e_code);
      for (int i = 0; i < 4; i++) begin
         check($sformatf("bank_open[%0d]", i), int'(bank_open[i]), int'(st[i] == 1));
         check($sformatf("bank_ap[%0d]", i), int'(bank_ap[i]), int'(st[i] == 2));
         check($sformatf("ras_overdue[%0d]", i), int'(ras_overdue[i]),
               int'(st[i] == 1 && (now - t_act[i]) > RAS_MAX));
         check($sformatf("bank_row[%0d]", i), int'(bank_row[i*13 +: 13]), rowm[i]);
      end
   endtask

   task automatic cyc(input int c_s, input int r, input int ca, input int w,
                      input int b, input int a);
      cs_n = c_s[0]; ras_n = r[0]; cas_n = ca[0]; we_n = w[0];
      ba = b[1:0]; addr = a[12:0];
      model_step(c_s, r, ca, w, b & 3, a & 13'h1fff);
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic nop(input int n);        repeat (n) cyc(0, 1, 1, 1, 0, 0); endtask
   task automatic act(input int b, input int row); cyc(0, 0, 1, 1, b, row); endtask
   task automatic rd(input int b, input int ap);   cyc(0, 1, 0, 1, b, ap ? 1024 : 5); endtask
   task automatic wr(input int b, input int ap);   cyc(0, 1, 0, 0, b, ap ? 1024 : 9); endtask
   task automatic pre(input int b);        cyc(0, 0, 1, 0, b, 0); endtask
   task automatic preall(input int b);     cyc(0, 0, 1, 0, b, 1024); endtask

   initial begin
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      rst_n = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 0; addr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      req = "R1"; compare_all();            // reset state
      rst_n = 1'b1;
      nop(2);
      cyc(0, 1, 1, 0, 2, 0);                // R1 burst stop decodes and is legal
      cyc(0, 0, 0, 0, 0, 'h31);             // R1 mode set with all idle

      req = "R4"; rd(1, 0);                 // read to idle bank: state
      req = "R12";
      act(0, 'h1ab); nop(1);
      rd(0, 0); rd(0, 0);                   // gaps 2,3 below tRCD
      rd(0, 0);                             // gap 4: exactly at limit
      req = "R6";
      pre(0); nop(2); pre(0);               // below tRAS min
      pre(0);                               // at tRAS min, closes
      pre(0);                               // idle bank: legal no-op

      req = "R5";
      act(0, 'h0aa);                        // one edge after precharge: tRP
      act(1, 'h111); nop(8); pre(1); nop(3);
      act(1, 'h112);                        // tRP met, tRC not
      nop(1); act(1, 'h113);                // tRC met
      act(2, 'h222);                        // one edge after bank 1: tRRD
      nop(1); act(2, 'h223);                // tRRD met
      req = "R3";
      act(2, 'h999); act(1, 'h998);         // already open: state

      req = "R2";
      cyc(1, 0, 1, 1, 3, 'h777);            // deselected activate
      cyc(1, 0, 1, 0, 0, 1024);             // deselected precharge-all
      nop(1);

      req = "R6";
      nop(10); wr(2, 0); nop(1);
      pre(2); nop(2); pre(2);               // write recovery
      pre(2);                               // recovery met
      rd(1, 0); pre(1);                     // read burst not over
      nop(1); pre(1);

      req = "R7";
      nop(10); act(0, 'h040); act(3, 'h041);
      preall(2);                            // bank 0 too young: nothing closes
      nop(10); preall(1);                   // all close

      req = "R8";
      nop(12); act(3, 'h0c3); nop(3);
      rd(3, 1); rd(3, 0); pre(3); act(3, 'h0c4);
      repeat (8) act(3, 'h0c5);             // walk across closing window and tRC
      nop(3); wr(3, 1); wr(3, 0);
      repeat (12) act(3, 'h0c6);
      act(1, 'h0d1); nop(3); wr(1, 1); repeat (11) rd(1, 0);

      req = "R11";
      act(2, 'h0e2);
      cyc(0, 0, 0, 1, 0, 0);                // refresh with bank open
      nop(12); preall(0);
      cyc(0, 0, 0, 1, 0, 0);                // refresh inside tRP
      nop(3); cyc(0, 0, 0, 1, 0, 0);        // refresh legal
      cyc(0, 0, 0, 0, 0, 0); cyc(0, 1, 1, 0, 1, 0);

      req = "R10";
      nop(20); act(0, 'h0f0); nop(25); pre(0);

      req = "R9";
      for (int i = 0; i < 4000; i++) begin
         int r, b, a;
         r = $urandom % 100; b = $urandom % 4; a = $urandom % 8192;
         if (r < 45)      nop(1);
         else if (r < 55) cyc(1, $urandom % 2, $urandom % 2, $urandom % 2, b, a);
         else if (r < 70) act(b, a);
         else if (r < 78) cyc(0, 1, 0, 1, b, a);
         else if (r < 85) cyc(0, 1, 0, 0, b, a);
         else if (r < 94) cyc(0, 0, 1, 0, b, a);
         else if (r < 96) cyc(0, 0, 0, 1, b, a);
         else if (r < 97) cyc(0, 0, 0, 0, b, a);
         else             cyc(0, 1, 1, 0, b, a);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule